// File: doc/BRIEF.md
# Banked DRAM Command Sequencer

This block sits on the controller side of a multibank DRAM and turns a stream of read and write requests into a legal command stream. Each request names a bank, a row and a column. The block keeps a record of the open row in every bank. A request that finds its row already open goes straight to a column command. A request that finds another row open first closes that bank and then opens the wanted row. A request to a closed bank first opens the row. Per-bank cycle counters enforce the minimum spacing between commands. A column command may ask for the bank to close itself once the burst has ended.

A refresh timer runs alongside the request path. When the timer expires, the block lets the request in hand finish and waits for any self-closing banks to close. It then closes every bank that is still open, issues a refresh, and accepts nothing more until the recovery time has passed. When the over-temperature input is high, the refresh interval is halved. Commands are registered and change on the rising clock edge, at most one per cycle.

Top module: `dram_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cmd_o` is NOP (code 0) and `req_ready_o` is high, with every bank closed.
- R2: ACTIVATE (code 1) goes only to a closed bank, and only when at least T_RP cycles have passed since that bank closed.
- R3: READ (code 2) and WRITE (code 3) go only to an open bank, at least T_RCD cycles after its ACTIVATE and at least BURST_LEN/2 cycles after the previous READ or WRITE to the same bank.
- R4: PRECHARGE (code 4) closes one bank. It is issued only at least T_RAS cycles after that bank's ACTIVATE and once its burst has ended.
- R5: When a request hits the open row, its only command is READ or WRITE. When it misses an open bank, its commands are PRECHARGE, ACTIVATE, then READ or WRITE. When its bank is closed, its commands are ACTIVATE, then READ or WRITE. `cmd_bank_o` carries the request bank. `cmd_addr_o` carries the row on ACTIVATE and the column on READ or WRITE.
- R6: A read request ends in READ and a write request ends in WRITE. `cmd_ap_o` is high on that command exactly when the request asked for auto precharge.
- R7: After a column command with auto precharge, the bank closes itself without any command on the bus, at cycle max(ACTIVATE + T_RAS, column command + BURST_LEN/2). `req_ready_o` stays low for requests to that bank until it has closed. The next access to that bank starts with ACTIVATE.
- R8: REFRESH (code 6) is issued only when every bank is closed and T_RP has passed since the last close. PRECHARGE-ALL (code 5) closes every open bank and is issued only when each of them meets the R4 spacing. Neither command is issued while an accepted request has not yet received its column command.
- R9: With the temperature input low, two consecutive REFRESH commands are at least REF_INTERVAL+2 and at most REF_INTERVAL+60 cycles apart.
- R10: With the temperature input high, the bounds of R9 apply with REF_INTERVAL/2 in place of REF_INTERVAL.
- R11: For T_RFC cycles after a REFRESH, no command is issued and `req_ready_o` stays low.
- R12: A request is taken on a rising edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low until that request's column command has been issued, and every accepted request receives exactly one column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hot_i | input | 1 | Over-temperature flag; halves the refresh interval |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_ap_i | input | 1 | Close the bank after this burst |
| req_bank_i | input | BANK_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Starting column |
| cmd_o | output | 3 | Command code (0 NOP, 1 ACT, 2 RD, 3 WR, 4 PRE, 5 PRE-ALL, 6 REF) |
| cmd_bank_o | output | BANK_W | Bank of the command |
| cmd_addr_o | output | ADDR_W | Row on activate, column on read or write |
| cmd_ap_o | output | 1 | Auto precharge flag on read or write |

## Verification
Two events can meet in one cycle: the refresh timer can expire while a request is still working through its precharge, activate and column steps, and while other banks still have self-closing bursts pending. Continuous random traffic, with auto precharge on about a quarter of the requests, keeps requests in flight across every refresh boundary, and directed cases open, hit, miss and self-close rows first. A cycle-level reference model in the bench tracks the open row and the close time of every bank, the request in flight and the last refresh. Each command on the bus is judged legal or illegal against that model, and the spacing between refreshes is checked in both temperature phases.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_PREA = 3'd5,
      CMD_REF  = 3'd6
   } dram_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SERVE = 2'd1,
      ST_DRAIN = 2'd2,
      ST_RFC   = 2'd3
   } seq_state_e;

endpackage

// File: rtl/dram_bank_track.sv
module dram_bank_track #(
   parameter int ROW_W     = 14,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RAS     = 8,
   parameter int BURST_CYC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_i,
   input  logic             rw_i,
   input  logic             ap_i,
   input  logic             pre_i,
   input  logic [ROW_W-1:0] row_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o,
   output logic             act_ok_o,
   output logic             rw_ok_o,
   output logic             pre_ok_o,
   output logic             ap_pend_o
);

   localparam int TMAX_A = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int TMAX_B = (T_RAS > BURST_CYC) ? T_RAS : BURST_CYC;
   localparam int TMAX   = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
   localparam int CW     = $clog2(TMAX + 1);

   logic             open_q;
   logic [ROW_W-1:0] row_q;
   logic [CW-1:0]    rcd_q, rp_q, ras_q, burst_q;
   logic             ap_q;
   logic             self_close;

   assign self_close = ap_q && open_q && (ras_q == '0) && (burst_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         row_q   <= '0;
         rcd_q   <= '0;
         rp_q    <= '0;
         ras_q   <= '0;
         burst_q <= '0;
         ap_q    <= 1'b0;
      end else begin
         if (act_i) begin
            open_q <= 1'b1;
            row_q  <= row_i;
            rcd_q  <= CW'(T_RCD - 1);
            ras_q  <= CW'(T_RAS - 1);
         end else begin
            if (pre_i || self_close) open_q <= 1'b0;
            if (rcd_q != '0) rcd_q <= rcd_q - 1'b1;
            if (ras_q != '0) ras_q <= ras_q - 1'b1;
         end

         if (pre_i || self_close) rp_q <= CW'(T_RP - 1);
         else if (rp_q != '0)     rp_q <= rp_q - 1'b1;

         if (rw_i)                burst_q <= CW'(BURST_CYC - 1);
         else if (burst_q != '0)  burst_q <= burst_q - 1'b1;

         if (rw_i && ap_i)        ap_q <= 1'b1;
         else if (self_close)     ap_q <= 1'b0;
      end
   end

   assign open_o    = open_q;
   assign row_o     = row_q;
   assign ap_pend_o = ap_q;
   assign act_ok_o  = !open_q && (rp_q == '0);
   assign rw_ok_o   = open_q && !ap_q && (rcd_q == '0) && (burst_q == '0);
   assign pre_ok_o  = open_q && !ap_q && (ras_q == '0) && (burst_q == '0);

   AST_ACT_ON_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      act_i |-> (!open_q && rp_q == '0)); // R2
   AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      rw_i |-> (open_q && rcd_q == '0 && burst_q == '0)); // R3
   AST_PRE_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_i && open_q) |-> (ras_q == '0 && burst_q == '0)); // R4
   AST_CLOSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(open_q) |-> $past(pre_i || ap_q)); // R7

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
   parameter int REF_INTERVAL = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hot_i,
   input  logic ack_i,
   output logic due_o
);

   localparam int CNT_W = $clog2(REF_INTERVAL + 1);
   localparam logic [CNT_W-1:0] LIM_COOL = CNT_W'(REF_INTERVAL);
   localparam logic [CNT_W-1:0] LIM_HOT  = CNT_W'(REF_INTERVAL / 2);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   assign limit = hot_i ? LIM_HOT : LIM_COOL;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (ack_i)             cnt_q <= '0;
      else if (cnt_q != LIM_COOL) cnt_q <= cnt_q + 1'b1;
   end

   assign due_o = (cnt_q >= limit);

   AST_REF_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM_COOL); // R9
   AST_ACK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !due_o); // R10

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
   import dram_seq_pkg::*;
#(
   parameter int NUM_BANKS    = 4,
   parameter int ROW_W        = 14,
   parameter int COL_W        = 10,
   parameter int BURST_LEN    = 8,
   parameter int T_RCD        = 3,
   parameter int T_RP         = 3,
   parameter int T_RAS        = 8,
   parameter int T_RFC        = 12,
   parameter int REF_INTERVAL = 400,
   localparam int BANK_W      = $clog2(NUM_BANKS),
   localparam int ADDR_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hot_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic              req_write_i,
   input  logic              req_ap_i,
   input  logic [BANK_W-1:0] req_bank_i,
   input  logic [ROW_W-1:0]  req_row_i,
   input  logic [COL_W-1:0]  req_col_i,
   output logic [2:0]        cmd_o,
   output logic [BANK_W-1:0] cmd_bank_o,
   output logic [ADDR_W-1:0] cmd_addr_o,
   output logic              cmd_ap_o
);

   localparam int BURST_CYC = BURST_LEN / 2;
   localparam int RFC_W     = $clog2(T_RFC + 1);

   if ((NUM_BANKS < 2) || ((NUM_BANKS & (NUM_BANKS - 1)) != 0)) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if ((BURST_LEN != 4) && (BURST_LEN != 8)) begin : g_bad_burst
      $error("BURST_LEN must be 4 or 8");
   end
   if ((T_RCD < 1) || (T_RP < 1) || (T_RAS < 1) || (T_RFC < 1)) begin : g_bad_timing
      $error("timing constants must be at least 1");
   end
   if (REF_INTERVAL / 2 <= T_RFC + 2) begin : g_bad_interval
      $error("REF_INTERVAL too short for refresh recovery");
   end

   seq_state_e        state_q, state_n;
   logic              p_write_q, p_ap_q;
   logic [BANK_W-1:0] p_bank_q;
   logic [ROW_W-1:0]  p_row_q;
   logic [COL_W-1:0]  p_col_q;
   logic [RFC_W-1:0]  rfc_q;

   dram_cmd_e         cmd_n, cmd_q;
   logic [BANK_W-1:0] bank_n, bank_q;
   logic [ADDR_W-1:0] addr_n, addr_q;
   logic              ap_n, ap_q;

   logic [NUM_BANKS-1:0] open_v, act_ok_v, rw_ok_v, pre_ok_v, ap_v;
   logic [NUM_BANKS-1:0] act_ev, rw_ev, pre_ev;
   logic [ROW_W-1:0]     open_row [NUM_BANKS];
   logic                 all_quiet, all_closed, any_open, row_hit;
   logic                 ref_due, accept;

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      dram_bank_track #(
         .ROW_W     (ROW_W),
         .T_RCD     (T_RCD),
         .T_RP      (T_RP),
         .T_RAS     (T_RAS),
         .BURST_CYC (BURST_CYC)
      ) bank_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .act_i     (act_ev[g]),
         .rw_i      (rw_ev[g]),
         .ap_i      (p_ap_q),
         .pre_i     (pre_ev[g]),
         .row_i     (p_row_q),
         .open_o    (open_v[g]),
         .row_o     (open_row[g]),
         .act_ok_o  (act_ok_v[g]),
         .rw_ok_o   (rw_ok_v[g]),
         .pre_ok_o  (pre_ok_v[g]),
         .ap_pend_o (ap_v[g])
      );
   end

   dram_refresh_timer #(
      .REF_INTERVAL (REF_INTERVAL)
   ) refresh_i (
      .clk   (clk),
      .rst_n (rst_n),
      .hot_i (hot_i),
      .ack_i (cmd_n == CMD_REF),
      .due_o (ref_due)
   );

   always_comb begin
      all_quiet  = 1'b1;
      all_closed = 1'b1;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if ((open_v[b] && !pre_ok_v[b]) || ap_v[b]) all_quiet = 1'b0;
         if (!act_ok_v[b])                            all_closed = 1'b0;
      end
   end

   assign any_open    = |open_v;
   assign row_hit     = open_v[p_bank_q] && (open_row[p_bank_q] == p_row_q);
   assign req_ready_o = (state_q == ST_IDLE) && !ref_due && !ap_v[req_bank_i];
   assign accept      = req_valid_i && req_ready_o;

   always_comb begin
      state_n = state_q;
      cmd_n   = CMD_NOP;
      bank_n  = '0;
      addr_n  = '0;
      ap_n    = 1'b0;
      act_ev  = '0;
      rw_ev   = '0;
      pre_ev  = '0;
      unique case (state_q)
         ST_IDLE: begin
            if (ref_due)     state_n = ST_DRAIN;
            else if (accept) state_n = ST_SERVE;
         end
         ST_SERVE: begin
            bank_n = p_bank_q;
            if (row_hit) begin
               if (rw_ok_v[p_bank_q]) begin
                  cmd_n           = p_write_q ? CMD_WR : CMD_RD;
                  addr_n          = ADDR_W'(p_col_q);
                  ap_n            = p_ap_q;
                  rw_ev[p_bank_q] = 1'b1;
                  state_n         = ST_IDLE;
               end
            end else if (open_v[p_bank_q]) begin
               if (pre_ok_v[p_bank_q]) begin
                  cmd_n            = CMD_PRE;
                  pre_ev[p_bank_q] = 1'b1;
               end
            end else if (act_ok_v[p_bank_q]) begin
               cmd_n            = CMD_ACT;
               addr_n           = ADDR_W'(p_row_q);
               act_ev[p_bank_q] = 1'b1;
            end
         end
         ST_DRAIN: begin
            if (all_closed) begin
               cmd_n   = CMD_REF;
               state_n = ST_RFC;
            end else if (any_open && all_quiet) begin
               cmd_n  = CMD_PREA;
               pre_ev = open_v;
            end
         end
         ST_RFC: begin
            if (rfc_q == '0) state_n = ST_IDLE;
         end
         default: state_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         p_write_q <= 1'b0;
         p_ap_q    <= 1'b0;
         p_bank_q  <= '0;
         p_row_q   <= '0;
         p_col_q   <= '0;
         rfc_q     <= '0;
         cmd_q     <= CMD_NOP;
         bank_q    <= '0;
         addr_q    <= '0;
         ap_q      <= 1'b0;
      end else begin
         state_q <= state_n;
         cmd_q   <= cmd_n;
         bank_q  <= bank_n;
         addr_q  <= addr_n;
         ap_q    <= ap_n;
         if (accept) begin
            p_write_q <= req_write_i;
            p_ap_q    <= req_ap_i;
            p_bank_q  <= req_bank_i;
            p_row_q   <= req_row_i;
            p_col_q   <= req_col_i;
         end
         if (cmd_n == CMD_REF) rfc_q <= RFC_W'(T_RFC - 1);
         else if (rfc_q != '0) rfc_q <= rfc_q - 1'b1;
      end
   end

   assign cmd_o      = cmd_q;
   assign cmd_bank_o = bank_q;
   assign cmd_addr_o = addr_q;
   assign cmd_ap_o   = ap_q;

   AST_REF_BANKS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_REF) |-> (open_v == '0)); // R8
   AST_NO_TAKE_IN_RFC: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_REF) |-> !req_ready_o); // R11
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready_o); // R12
   AST_PREA_CLOSES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_PREA) |-> (open_v == '0)); // R8

endmodule

// File: tb/dram_cmd_seq_tb.sv
`timescale 1ns/1ps
module dram_cmd_seq_tb_top;

   localparam int NB     = 4;
   localparam int BC     = 4;
   localparam int T_RCD  = 3;
   localparam int T_RP   = 3;
   localparam int T_RAS  = 8;
   localparam int T_RFC  = 12;
   localparam int RI     = 400;
   localparam int C_NOP = 0, C_ACT = 1, C_RD = 2, C_WR = 3, C_PRE = 4, C_PREA = 5, C_REF = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hot = 1'b0;
   logic        valid = 1'b0;
   logic        wr = 1'b0;
   logic        apf = 1'b0;
   logic [1:0]  bank = '0;
   logic [13:0] row = '0;
   logic [9:0]  col = '0;
   logic        ready;
   logic [2:0]  cmd;
   logic [1:0]  cbank;
   logic [13:0] caddr;
   logic        cap;

   always #2 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   dram_cmd_seq dut_i (
      .clk(clk), .rst_n(rst_n), .hot_i(hot),
      .req_valid_i(valid), .req_ready_o(ready), .req_write_i(wr), .req_ap_i(apf),
      .req_bank_i(bank), .req_row_i(row), .req_col_i(col),
      .cmd_o(cmd), .cmd_bank_o(cbank), .cmd_addr_o(caddr), .cmd_ap_o(cap)
   );

   int checks = 0, errors = 0;
   bit m_open [NB];
   int m_row [NB], m_act [NB], m_rw [NB], m_close [NB];
   bit m_ap [NB];
   bit p_busy = 0, p_write, p_ap;
   int p_bank, p_row, p_col, exp_n, exp_i;
   int exp_cmd [3];
   int last_ref = -1, hot_chg = 0, ref_cool = 0, ref_hot = 0;
   bit acc_next = 0;
   int dir_i = 0;
   int d_bank [7] = '{0, 0, 0, 1, 1, 2, 2};
   int d_row  [7] = '{5, 5, 9, 2, 2, 7, 7};
   int d_wr   [7] = '{0, 1, 0, 1, 0, 0, 1};
   int d_ap   [7] = '{0, 0, 0, 1, 0, 0, 0};

   task automatic check(input bit ok, input string req, input string what,
                        input longint actual, input longint expected);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, actual, expected, cyc);
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic seq_match(input int c, input int b, input int a, input bit f);
      if (!p_busy) begin
         check(1'b0, "R12", "command with no request in flight", c, C_NOP);
      end else begin
         check(c == exp_cmd[exp_i], (c == C_RD || c == C_WR) ? "R6" : "R5",
               "command kind", c, exp_cmd[exp_i]);
         check(b == p_bank, "R5", "command bank", b, p_bank);
         if (c == C_ACT) check(a == p_row, "R5", "activate row", a, p_row);
         if (c == C_RD || c == C_WR) begin
            check(a == p_col, "R5", "column", a, p_col);
            check(f == p_ap, "R6", "auto precharge flag", f, p_ap);
         end
         exp_i++;
         if (exp_i >= exp_n || c == C_RD || c == C_WR) p_busy = 0;
      end
   endtask

   task automatic step(input bit drive);
      int now, c, b, lim, gap;
      bit ok;
      @(negedge clk);
      now = cyc;
      for (int k = 0; k < NB; k++) begin
         if (m_ap[k] && now >= imax(m_act[k] + T_RAS, m_rw[k] + BC)) begin
            m_open[k]  = 0;
            m_close[k] = imax(m_act[k] + T_RAS, m_rw[k] + BC);
            m_ap[k]    = 0;
         end
      end
      c = int'(cmd);
      b = int'(cbank);
      if (c != C_NOP && last_ref >= 0 && now != last_ref)
         check(now - last_ref > T_RFC, "R11", "command inside refresh recovery", now - last_ref, T_RFC + 1);
      case (c)
         C_ACT: begin
            check(!m_open[b] && now - m_close[b] >= T_RP, "R2", "activate spacing", now - m_close[b], T_RP);
            seq_match(c, b, int'(caddr), cap);
            m_open[b] = 1; m_row[b] = int'(caddr); m_act[b] = now;
         end
         C_RD, C_WR: begin
            check(m_open[b] && now - m_act[b] >= T_RCD, "R3", "column after activate", now - m_act[b], T_RCD);
            check(now - m_rw[b] >= BC, "R3", "column after column", now - m_rw[b], BC);
            seq_match(c, b, int'(caddr), cap);
            m_rw[b] = now; m_ap[b] = cap;
         end
         C_PRE: begin
            check(m_open[b] && !m_ap[b] && now - m_act[b] >= T_RAS && now - m_rw[b] >= BC,
                  "R4", "precharge spacing", now - m_act[b], T_RAS);
            seq_match(c, b, int'(caddr), cap);
            m_open[b] = 0; m_close[b] = now;
         end
         C_PREA: begin
            check(!p_busy, "R8", "precharge-all with request in flight", p_busy, 0);
            for (int k = 0; k < NB; k++) begin
               if (m_open[k]) begin
                  check(!m_ap[k] && now - m_act[k] >= T_RAS && now - m_rw[k] >= BC,
                        "R8", "precharge-all spacing", now - m_act[k], T_RAS);
                  m_open[k] = 0; m_close[k] = now;
               end
            end
         end
         C_REF: begin
            check(!p_busy, "R8", "refresh with request in flight", p_busy, 0);
            ok = 1;
            for (int k = 0; k < NB; k++)
               if (m_open[k] || now - m_close[k] < T_RP) ok = 0;
            check(ok, "R8", "refresh with bank not closed", 0, 1);
            if (last_ref >= 0 && hot_chg <= last_ref) begin
               lim = hot ? RI / 2 : RI;
               gap = now - last_ref;
               check(gap >= lim + 2 && gap <= lim + 60, hot ? "R10" : "R9", "refresh gap", gap, lim + 2);
               if (hot) ref_hot++; else ref_cool++;
            end
            last_ref = now;
         end
         C_NOP: ;
         default: check(1'b0, "R5", "unknown command code", c, 0);
      endcase

      if (acc_next) begin
         if (last_ref >= 0)
            check(now - last_ref > T_RFC, "R11", "request taken in recovery", now - last_ref, T_RFC + 1);
         p_busy = 1; p_bank = int'(bank); p_row = int'(row); p_col = int'(col);
         p_write = wr; p_ap = apf; exp_i = 0;
         if (m_open[p_bank] && m_row[p_bank] == p_row) begin
            exp_n = 1; exp_cmd[0] = p_write ? C_WR : C_RD;
         end else if (m_open[p_bank]) begin
            exp_n = 3; exp_cmd[0] = C_PRE; exp_cmd[1] = C_ACT; exp_cmd[2] = p_write ? C_WR : C_RD;
         end else begin
            exp_n = 2; exp_cmd[0] = C_ACT; exp_cmd[1] = p_write ? C_WR : C_RD;
         end
         valid = 1'b0;
      end

      if (drive && !valid) begin
         if (dir_i < 7) begin
            bank = 2'(d_bank[dir_i]); row = 14'(d_row[dir_i]); wr = d_wr[dir_i][0];
            apf = d_ap[dir_i][0]; col = 10'(dir_i * 17); valid = 1'b1; dir_i++;
         end else if ($urandom % 10 < 7) begin
            bank = 2'($urandom % NB); row = 14'($urandom % 4); col = 10'($urandom % 1024);
            wr = 1'($urandom % 2); apf = ($urandom % 4 == 0); valid = 1'b1;
         end
      end

      #1;
      if (ready) begin
         check(!m_ap[int'(bank)], "R7", "ready while bank self-closing", ready, 0);
         check(!p_busy, "R12", "ready while request in flight", ready, 0);
         if (last_ref >= 0)
            check(now + 1 - last_ref > T_RFC, "R11", "ready in recovery", now + 1 - last_ref, T_RFC + 1);
      end
      acc_next = valid && ready;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cyc, 200000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < NB; k++) begin
         m_open[k] = 0; m_row[k] = 0; m_act[k] = -1000; m_rw[k] = -1000;
         m_close[k] = -1000; m_ap[k] = 0;
      end
      repeat (5) begin
         @(negedge clk);
         check(cmd == 3'd0, "R1", "command during reset", cmd, 0);
      end
      rst_n = 1'b1;
      #1;
      check(ready == 1'b1, "R1", "ready after reset", ready, 1);
      @(negedge clk);
      check(cmd == 3'd0, "R1", "command after reset", cmd, 0);
      for (int i = 0; i < 12000; i++) begin
         if (i == 5000) begin hot = 1'b1; hot_chg = cyc; end
         if (i == 9000) begin hot = 1'b0; hot_chg = cyc; end
         step(i < 11700);
      end
      check(!p_busy, "R12", "request left without column command", p_busy, 0);
      check(ref_cool >= 3, "R9", "cool refresh intervals seen", ref_cool, 3);
      check(ref_hot >= 3, "R10", "hot refresh intervals seen", ref_hot, 3);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule